// File: doc/BRIEF.md
# In-Lane Dword Shuffle Unit

This block reorders 32-bit elements inside each 128-bit lane of a 256-bit vector. Every lane holds four dwords. Each result dword is taken from one of the four dwords in the same lane of the source, and a 2-bit selector chooses which one. No data ever moves between lanes.

The selectors come from one of two places. In immediate mode, an 8-bit immediate holds four 2-bit fields, and the same fields drive every lane. In variable mode, each result dword takes its selector from the two least significant bits of the matching dword of a control vector. All other control bits are ignored. A length input chooses full 256-bit operation or 128-bit operation. At 128-bit length, the upper half of the result is cleared.

The result and its valid flag are registered one cycle after the request strobe. The registers reset synchronously.

Top module: `pshuf_unit`

## Requirements
- R1: In immediate mode (`mode_var`=0), result dword k of a lane (k=0..3) uses immediate bits [2k+1:2k] as its selector.
- R2: A selector value n (0..3) places source dword n of the same 128-bit lane into the result dword. Nothing is read from another lane.
- R3: The upper lane (bits 255:128) uses the same four immediate fields as the lower lane.
- R4: In variable mode (`mode_var`=1), the selector for result dword j (j=0..7, bits 32j+31:32j) is `ctrl` bits [32j+1:32j]. All other `ctrl` bits and the whole immediate have no effect on the result.
- R5: When `len_full`=0, result bits 255:128 are zero and bits 127:0 follow R1 to R4. When `len_full`=1, both lanes are computed.
- R6: A request presented with `in_valid`=1 at a rising edge appears on `result`, with `out_valid`=1, right after that edge.
- R7: At an edge where `in_valid`=0, `out_valid` falls to 0 and `result` keeps its previous value.
- R8: A synchronous reset (`rst`=1 at an edge) clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| mode_var | input | 1 | 0: immediate selectors, 1: per-dword control selectors |
| len_full | input | 1 | 1: 256-bit operation, 0: 128-bit with upper half cleared |
| imm | input | 8 | Four 2-bit selector fields |
| src | input | 256 | Source vector |
| ctrl | input | 256 | Per-dword control vector for variable mode |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Shuffled vector |

## Verification
The bench sweeps all 256 immediate values on random data. A wrong field-to-dword mapping, or an upper lane that reads the wrong fields or crosses into the lower lane, would therefore produce a mismatch for some immediate. In variable mode, the control dwords carry random high bits, so a decoder that used bit 2 or above would pick the wrong dword or the wrong lane. Short-length requests check that the upper half is cleared and not left stale. Idle cycles after a request check that the result is held and not recomputed from the current inputs.

// File: rtl/pshuf_pkg.sv
package pshuf_pkg;
    localparam int unsigned ELEM_W     = 32;
    localparam int unsigned LANE_ELEMS = 4;
    localparam int unsigned SEL_W      = $clog2(LANE_ELEMS);
    localparam int unsigned LANE_W     = ELEM_W * LANE_ELEMS;
    localparam int unsigned IMM_W      = SEL_W * LANE_ELEMS;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/pshuf_sel_gen.sv
module pshuf_sel_gen
    import pshuf_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic                                  mode_var,
    input  logic [IMM_W-1:0]                      imm,
    input  logic [LANES*LANE_W-1:0]               ctrl,
    output logic [LANES*LANE_ELEMS*SEL_W-1:0]     sel_flat
);
    localparam int unsigned N_ELEMS = LANES * LANE_ELEMS;

    for (genvar j = 0; j < N_ELEMS; j++) begin : g_sel
        localparam int unsigned FIELD = j % LANE_ELEMS;
        sel_t imm_sel;
        sel_t var_sel;
        always_comb begin
            imm_sel = imm[FIELD*SEL_W +: SEL_W];
            var_sel = ctrl[j*ELEM_W +: SEL_W];
            sel_flat[j*SEL_W +: SEL_W] = mode_var ? var_sel : imm_sel;
        end
    end
endmodule

// File: rtl/pshuf_lane.sv
module pshuf_lane
    import pshuf_pkg::*;
(
    input  lane_t                        src,
    input  logic [LANE_ELEMS*SEL_W-1:0]  sel,
    output lane_t                        dst
);
    for (genvar k = 0; k < LANE_ELEMS; k++) begin : g_elem
        sel_t s;
        always_comb begin
            s = sel[k*SEL_W +: SEL_W];
            dst[k*ELEM_W +: ELEM_W] = src[s*ELEM_W +: ELEM_W];
        end
    end
endmodule

// File: rtl/pshuf_unit.sv
module pshuf_unit
    import pshuf_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     mode_var,
    input  logic                     len_full,
    input  logic [IMM_W-1:0]         imm,
    input  logic [LANES*LANE_W-1:0]  src,
    input  logic [LANES*LANE_W-1:0]  ctrl,
    output logic                     out_valid,
    output logic [LANES*LANE_W-1:0]  result
);
    localparam int unsigned DATA_W  = LANES * LANE_W;
    localparam int unsigned SEL_ALL = LANES * LANE_ELEMS * SEL_W;
    localparam int unsigned LOW_LANES = (LANES > 1) ? LANES / 2 : 1;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } state_t;

    state_t state_d, state_q;
    logic [SEL_ALL-1:0] sel_all;
    logic [DATA_W-1:0]  shuf;

    pshuf_sel_gen #(.LANES(LANES)) u_sel (
        .mode_var (mode_var),
        .imm      (imm),
        .ctrl     (ctrl),
        .sel_flat (sel_all)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_t lane_out;
        pshuf_lane u_lane (
            .src (src[l*LANE_W +: LANE_W]),
            .sel (sel_all[l*LANE_ELEMS*SEL_W +: LANE_ELEMS*SEL_W]),
            .dst (lane_out)
        );
        if (l < LOW_LANES) begin : g_low
            assign shuf[l*LANE_W +: LANE_W] = lane_out;
        end else begin : g_high
            assign shuf[l*LANE_W +: LANE_W] = len_full ? lane_out : '0;
        end
    end

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = shuf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;

    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(rst)) |=> $stable(result) || $past(rst));

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !len_full) |=> result[DATA_W-1:LOW_LANES*LANE_W] == '0);

    // R1
    identity_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_var && len_full && imm == 8'hE4) |=> result == $past(src));
endmodule

// File: tb/tb_pshuf_unit.sv
module tb_pshuf_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         mode_var;
    logic         len_full;
    logic [7:0]   imm;
    logic [255:0] src;
    logic [255:0] ctrl;
    logic         out_valid;
    logic [255:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pshuf_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_var(mode_var),
        .len_full(len_full), .imm(imm), .src(src), .ctrl(ctrl),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [255:0] model(input logic [255:0] s, input logic [255:0] c,
                                           input logic [7:0] im, input logic mv, input logic lf);
        logic [255:0] r;
        r = '0;
        for (int j = 0; j < 8; j++) begin
            int lane;
            int sel;
            lane = j / 4;
            sel  = mv ? int'(c[32*j +: 2]) : int'(im[2*(j%4) +: 2]);
            if (lane == 0 || lf) r[32*j +: 32] = s[128*lane + 32*sel +: 32];
        end
        return r;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [255:0] s, input logic [255:0] c,
                          input logic [7:0] im, input logic mv, input logic lf);
        @(negedge clk);
        src = s; ctrl = c; imm = im; mode_var = mv; len_full = lf; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R6 valid"}, {255'd0, out_valid}, 256'd1);
        check(req, result, model(s, c, im, mv, lf));
    endtask

    initial begin
        #1_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [255:0] s, c, held;
        void'($urandom(32'd7041));
        rst = 1'b1; in_valid = 1'b0; mode_var = 1'b0; len_full = 1'b1;
        imm = '0; src = '1; ctrl = '1;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 result", result, '0);
        check("R8 valid", {255'd0, out_valid}, '0);
        rst = 1'b0;

        // R1 R2 R3: sweep every immediate on random data
        for (int i = 0; i < 256; i++) begin
            run_op("R1 R2 R3 imm sweep", rnd256(), rnd256(), 8'(i), 1'b0, 1'b1);
        end
        // directed: distinct dwords, broadcast of each index
        s = 256'h77777777_66666666_55555555_44444444_33333333_22222222_11111111_00000000;
        run_op("R2 bcast0", s, '0, 8'h00, 1'b0, 1'b1);
        run_op("R2 bcast3", s, '0, 8'hFF, 1'b0, 1'b1);
        run_op("R3 reverse", s, '0, 8'h1B, 1'b0, 1'b1);

        // R4: variable mode with random high control bits
        for (int i = 0; i < 64; i++) begin
            run_op("R4 var", rnd256(), rnd256(), 8'($urandom), 1'b1, 1'b1);
        end
        c = '0;
        for (int j = 0; j < 8; j++) c[32*j +: 32] = 32'hFFFF_FFFC | 32'(3 - (j % 4));
        run_op("R4 high bits ignored", s, c, 8'hE4, 1'b1, 1'b1);

        // R5: 128-bit length
        for (int i = 0; i < 32; i++) begin
            run_op("R5 short imm", rnd256(), rnd256(), 8'($urandom), 1'b0, 1'b0);
            run_op("R5 short var", rnd256(), rnd256(), 8'($urandom), 1'b1, 1'b0);
        end

        // R7: hold while idle, with inputs changing
        run_op("R7 setup", s, '0, 8'h4E, 1'b0, 1'b1);
        held = model(s, '0, 8'h4E, 1'b0, 1'b1);
        src = rnd256(); imm = 8'h00;
        repeat (2) @(negedge clk);
        check("R7 hold", result, held);
        check("R7 valid low", {255'd0, out_valid}, '0);

        // R8: reset after activity
        @(negedge clk); in_valid = 1'b1; rst = 1'b1;
        @(negedge clk); in_valid = 1'b0; rst = 1'b0;
        check("R8 reclear", result, '0);
        check("R8 valid reclear", {255'd0, out_valid}, '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule